// File: doc/BRIEF.md
# AES-64 Key Expansion Word Step

This unit computes the first half of one AES key-expansion step for a 64-bit scalar datapath. A 64-bit source operand and a 4-bit round number enter together. The unit processes only the upper 32-bit word of the source. For an ordinary round it rotates that word right by one byte, passes each byte through the forward AES S-box and mixes a round constant into the low byte. The resulting 32-bit word is written into both halves of the 64-bit result.

Round number 0xA marks the final round. For this code the word is not rotated and no round constant is added. Round numbers above 0xA are reserved. They raise an illegal-immediate flag and force a zero result.

The substitution, rotation and constant selection are combinational. A single output register holds the result. The unit never stalls, so it accepts one operation in every cycle and returns each result one cycle after it was accepted.

Top module: `ks_step_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_illegal` and `out_result` are all cleared to zero after that edge.
- R2: `in_ready` is always 1. `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1.
- R3: Bits 31:0 of `src_op` have no effect on `out_result`.
- R4: For round numbers 0 through 9, the word `src_op[63:32]` is rotated right by 8 bits. Each of its four bytes is then replaced by its forward AES S-box value, and every byte stays in its position.
- R5: For round numbers 0 through 9, a round constant is XORed into bits 7:0 of the substituted word. The constants for rounds 0 to 9 are 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80, 0x1B and 0x36.
- R6: For round number 0xA, the word is substituted with no rotation, and no constant is added.
- R7: The final 32-bit word appears in both `out_result[63:32]` and `out_result[31:0]`.
- R8: For round numbers 0xB through 0xF, `out_illegal` is 1 and `out_result` is zero. For rounds 0x0 to 0xA, `out_illegal` is 0.
- R9: In a cycle with `in_valid` low, `out_result` and `out_illegal` keep their previous values.
- R10: Operations presented in consecutive cycles each produce their own correct result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_ready | output | 1 | Always 1; the unit accepts every cycle |
| src_op | input | 64 | Source operand; only the upper word is used |
| rnd_num | input | 4 | Round-number immediate (0x0 to 0xA legal) |
| out_valid | output | 1 | The result registers hold a new result |
| out_result | output | 64 | Transformed word, duplicated into both halves |
| out_illegal | output | 1 | The accepted round number was reserved |

## Verification
The assertions check the timing and structure on every cycle:
- the one-cycle valid pipeline and the constant `in_ready`;
- equal result halves;
- zero result with the flag raised for reserved round numbers;
- held outputs in idle cycles.

Only the bench's scenarios can show that the substituted bytes, the rotation and the round constant are correct. For this, the bench compares every round number with random operands against a model that builds its S-box by a separate method. Directed scenarios cover the following:
- a known key-expansion word;
- the final-round code;
- the reserved codes;
- changes to the lower operand word;
- back-to-back issue.

// File: rtl/ks_pkg.sv
// Package for the key-expansion word step.
// Holds the widths, the GF(2^8) arithmetic and the forward S-box function.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package ks_pkg;

    localparam int BYTE_W = 8;

    // Multiply two field elements (shift-and-add with reduction by 0x1B).
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        acc = 8'h00;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = aa[7] ? ({aa[6:0], 1'b0} ^ 8'h1B) : {aa[6:0], 1'b0};
        end
        return acc;
    endfunction

    // Multiplicative inverse as x^254 (zero maps to zero).
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] sq;
        logic [7:0] acc;
        sq  = gf_mul(x, x);
        acc = 8'h01;
        for (int i = 1; i < 8; i++) begin
            acc = gf_mul(acc, sq);
            sq  = gf_mul(sq, sq);
        end
        return acc;
    endfunction

    // Forward S-box: field inverse followed by the affine map.
    function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
        logic [7:0] v;
        logic [7:0] y;
        v = gf_inv(x);
        y = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]};
        return y ^ 8'h63;
    endfunction

endpackage

// File: rtl/ks_word_prep.sv
// Word preparation stage.
// Selects the upper operand word, rotates it right by one byte for ordinary
// rounds, and picks the round constant and the reserved-code flag.
// Assumes FINAL_RND is the single code that skips rotation and constant.
module ks_word_prep #(
    parameter int DATA_W    = 64,
    parameter int RNUM_W    = 4,
    parameter int FINAL_RND = 10,
    parameter int ROT_BITS  = 8
) (
    input  logic [DATA_W-1:0]   src,
    input  logic [RNUM_W-1:0]   rnd,
    output logic [DATA_W/2-1:0] word_out,
    output logic [7:0]          rcon_out,
    output logic                reserved
);
    localparam int WORD_W = DATA_W / 2;

    logic [WORD_W-1:0] upper;
    logic              is_final;

    assign upper    = src[DATA_W-1:WORD_W];
    assign is_final = (rnd == RNUM_W'(FINAL_RND));
    assign reserved = (rnd > RNUM_W'(FINAL_RND));

    // Rotation: ordinary rounds rotate right, the final code passes through.
    always_comb begin
        if (is_final) word_out = upper;
        else          word_out = {upper[ROT_BITS-1:0], upper[WORD_W-1:ROT_BITS]};
    end

    // Round-constant selection; zero for the final and reserved codes.
    always_comb begin
        case (rnd)
            RNUM_W'(0): rcon_out = 8'h01;
            RNUM_W'(1): rcon_out = 8'h02;
            RNUM_W'(2): rcon_out = 8'h04;
            RNUM_W'(3): rcon_out = 8'h08;
            RNUM_W'(4): rcon_out = 8'h10;
            RNUM_W'(5): rcon_out = 8'h20;
            RNUM_W'(6): rcon_out = 8'h40;
            RNUM_W'(7): rcon_out = 8'h80;
            RNUM_W'(8): rcon_out = 8'h1B;
            RNUM_W'(9): rcon_out = 8'h36;
            default:    rcon_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/ks_sbox_lane.sv
// One byte lane of forward S-box substitution.
// Purely combinational; no assumptions beyond the AES field.
module ks_sbox_lane (
    input  logic [7:0] din,
    output logic [7:0] dout
);
    // Substitute the lane byte.
    always_comb dout = ks_pkg::sbox_fwd(din);
endmodule

// File: rtl/ks_out_stage.sv
// Output register stage.
// Captures the duplicated word and the reserved flag on each accepted
// operation and holds them while idle. Reserved codes store zero.
module ks_out_stage #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [WORD_W-1:0]   word_in,
    input  logic                reserved_in,
    output logic                valid_q,
    output logic [2*WORD_W-1:0] result_q,
    output logic                illegal_q
);
    // Valid flag follows the accept strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= take;
    end

    // Result and flag registers, written only on an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q  <= '0;
            illegal_q <= 1'b0;
        end else if (take) begin
            result_q  <= reserved_in ? '0 : {word_in, word_in};
            illegal_q <= reserved_in;
        end
    end
endmodule

// File: rtl/ks_step_unit.sv
// Top level: key-expansion word step on a 64-bit operand.
// Prepares the upper word, substitutes each byte in its own lane, adds the
// round constant into the low byte and registers the duplicated result.
// Assumes a new operation may arrive every cycle; it never back-pressures.
module ks_step_unit #(
    parameter int DATA_W    = 64,
    parameter int RNUM_W    = 4,
    parameter int FINAL_RND = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] src_op,
    input  logic [RNUM_W-1:0] rnd_num,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);
    localparam int WORD_W = DATA_W / 2;
    localparam int LANES  = WORD_W / ks_pkg::BYTE_W;

    logic [WORD_W-1:0] prep_word;
    logic [WORD_W-1:0] sub_word;
    logic [WORD_W-1:0] mixed_word;
    logic [7:0]        rcon;
    logic              reserved;

    assign in_ready = 1'b1;

    ks_word_prep #(
        .DATA_W(DATA_W), .RNUM_W(RNUM_W), .FINAL_RND(FINAL_RND), .ROT_BITS(ks_pkg::BYTE_W)
    ) u_prep (
        .src(src_op), .rnd(rnd_num), .word_out(prep_word),
        .rcon_out(rcon), .reserved(reserved)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ks_sbox_lane u_lane (
            .din (prep_word[g*8 +: 8]),
            .dout(sub_word[g*8 +: 8])
        );
    end

    // Round-constant mix into the least significant byte.
    always_comb begin
        mixed_word      = sub_word;
        mixed_word[7:0] = sub_word[7:0] ^ rcon;
    end

    ks_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk(clk), .rst_n(rst_n), .take(in_valid), .word_in(mixed_word),
        .reserved_in(reserved), .valid_q(out_valid), .result_q(out_result),
        .illegal_q(out_illegal)
    );
endmodule

// File: rtl/ks_step_unit_chk.sv
// Checker for ks_step_unit: pipeline timing, output structure, reserved codes
// and idle hold. Bound to every instance of the top module.
module ks_step_unit_chk #(
    parameter int DATA_W    = 64,
    parameter int RNUM_W    = 4,
    parameter int FINAL_RND = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] src_op,
    input logic [RNUM_W-1:0] rnd_num,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_illegal
);
    localparam int WORD_W = DATA_W / 2;

    // R2
    ready_const_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R7
    halves_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_result[DATA_W-1:WORD_W] == out_result[WORD_W-1:0]);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(rnd_num) > RNUM_W'(FINAL_RND)))
        |-> (out_illegal && out_result == '0));

    // R8
    legal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(rnd_num) <= RNUM_W'(FINAL_RND)))
        |-> !out_illegal);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_result) && $stable(out_illegal)));
endmodule

bind ks_step_unit ks_step_unit_chk #(
    .DATA_W(DATA_W), .RNUM_W(RNUM_W), .FINAL_RND(FINAL_RND)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_op(src_op), .rnd_num(rnd_num), .out_valid(out_valid),
    .out_result(out_result), .out_illegal(out_illegal)
);

// File: tb/sim_ks_step_unit.sv
// Directed bench for ks_step_unit; one task per scenario.
module sim_ks_step_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] src_op = '0;
    logic [3:0]  rnd_num = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_illegal;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] sb [0:255];

    always #10 clk = ~clk;

    ks_step_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_op(src_op), .rnd_num(rnd_num), .out_valid(out_valid),
        .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    // Build the S-box by walking generator 3 and its inverse together.
    task automatic build_sbox();
        logic [7:0] p = 8'h01;
        logic [7:0] q = 8'h01;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'h0};
            if (q[7]) q = q ^ 8'h09;
            sb[p] = q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    endtask

    function automatic logic [7:0] rc_model(input logic [3:0] r);
        logic [7:0] c = 8'h01;
        for (int i = 0; i < int'(r); i++) c = c[7] ? ({c[6:0], 1'b0} ^ 8'h1B) : {c[6:0], 1'b0};
        return c;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] s, input logic [3:0] r);
        logic [31:0] w = s[63:32];
        logic [7:0]  c = 8'h00;
        if (r > 4'hA) return 64'h0;
        if (r != 4'hA) begin
            w = {w[7:0], w[31:8]};
            c = rc_model(r);
        end
        w = {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
        w[7:0] = w[7:0] ^ c;
        return {w, w};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one operation and check its result at the next falling edge.
    task automatic run_one(input string req, input logic [63:0] s, input logic [3:0] r);
        @(negedge clk);
        src_op = s; rnd_num = r; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 64'(out_valid), 64'h1);
        check(req, out_result, model(s, r));
        check({req, " flag"}, 64'(out_illegal), (r > 4'hA) ? 64'h1 : 64'h0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", 64'(out_valid), 64'h0);
        check("R1 out_result", out_result, 64'h0);
        check("R1 out_illegal", 64'(out_illegal), 64'h0);
        check("R2 in_ready", 64'(in_ready), 64'h1);
        rst_n = 1'b1;
    endtask

    task automatic t_known_word();
        // R4 R5 R7: round 0 on a known expansion word
        run_one("R4", {32'h3c4fcf09, 32'h0}, 4'h0);
        check("R5 known", out_result, 64'h01eb848b_01eb848b);
    endtask

    task automatic t_all_rounds();
        for (int r = 0; r < 10; r++) begin
            for (int k = 0; k < 6; k++) run_one("R5", {$urandom, $urandom}, 4'(r));
        end
        for (int k = 0; k < 6; k++) run_one("R6", {$urandom, $urandom}, 4'hA);
        run_one("R6 known", {32'h3c4fcf09, 32'h0}, 4'hA);
        check("R6 value", out_result, {2{sb[8'h3c], sb[8'h4f], sb[8'hcf], sb[8'h09]}});
    endtask

    task automatic t_lower_ignored();
        logic [63:0] first;
        run_one("R3 base", {32'h12345678, 32'h00000000}, 4'h3);
        first = out_result;
        run_one("R3 lower", {32'h12345678, 32'hFFFFFFFF}, 4'h3);
        check("R3", out_result, first);
        run_one("R3 lower2", {32'h12345678, 32'hA5A5A5A5}, 4'h3);
        check("R3", out_result, first);
    endtask

    task automatic t_reserved();
        for (int r = 11; r < 16; r++) run_one("R8", {$urandom, $urandom}, 4'(r));
    endtask

    task automatic t_hold();
        logic [63:0] keep;
        run_one("R9 setup", {$urandom, $urandom}, 4'h7);
        keep = out_result;
        @(negedge clk);
        src_op = {$urandom, $urandom}; rnd_num = 4'hC;
        repeat (3) @(negedge clk);
        check("R9 result", out_result, keep);
        check("R9 flag", 64'(out_illegal), 64'h0);
        check("R2 idle", 64'(out_valid), 64'h0);
    endtask

    task automatic t_back_to_back();
        logic [63:0] s [8];
        logic [3:0]  r [8];
        for (int i = 0; i < 8; i++) begin
            s[i] = {$urandom, $urandom};
            r[i] = 4'(i + 5);
        end
        @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            if (i > 0) begin
                check("R10 valid", 64'(out_valid), 64'h1);
                check("R10", out_result, model(s[i-1], r[i-1]));
            end
            if (i < 8) begin
                src_op = s[i]; rnd_num = r[i]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        check("R2 drop", 64'(out_valid), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        build_sbox();
        t_reset();
        t_known_word();
        t_all_rounds();
        t_lower_ignored();
        t_reserved();
        t_hold();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule